// File: doc/BRIEF.md
# Per-Slave Security Request Filter

The filter sits on the request path between interconnect masters and a small set of slave ports. Every request carries its own protection bit, so one master may mix secure and nonsecure transfers. For the targeted slave the filter compares that bit against the slave's active security setting. A permitted request goes to that slave with its fields unchanged. A refused request never reaches a slave. The filter accepts it and answers it with a locally built decode-error response. Slave responses go back upstream through a fixed-priority multiplexer. Once a slave has started a multi-beat burst, the multiplexer stays on that slave until the last beat.

Software sets each slave's setting through a small configuration port. The port accepts only secure accesses. Its settings can be written but never read back. A written change is first held as pending. The filter stalls new requests to that slave until the slave's count of outstanding transactions drains to zero. The change then moves into the active setting, and new requests are judged against the new value.

Top module: `sec_filter`

## Requirements
- R1: After reset every slave is secure: a nonsecure request to any slave is refused, and no response or forwarded request is active.
- R2: A secure request to an existing slave is always forwarded. A nonsecure request is forwarded only to a slave whose active setting is nonsecure. Forwarding raises only that slave's bit of `m_valid` and passes write, ID, length and data unchanged.
- R3: A refused request never raises `m_valid`. It is accepted and answered with `rsp_resp` = 2'b11, the request's ID and zero data. A write (`req_write`=1) gets one beat. A read gets `req_len`+1 beats, with `rsp_last` set only on the final beat.
- R4: A secure configuration access gets `cfg_rsp` = 2'b00 in the cycle after `cfg_valid`. A write stores `cfg_wdata` for slave `cfg_sel`, where 1 means secure and 0 means nonsecure. A read stores nothing and returns no setting.
- R5: A nonsecure configuration access, or one with `cfg_sel` at or above the slave count, gets `cfg_rsp` = 2'b11 in the next cycle and changes no setting.
- R6: A change to a slave's setting waits while that slave has outstanding transactions. While the change is pending, requests to that slave are stalled (`req_ready`=0, no `m_valid`). The new setting applies in the first cycle with zero outstanding, and requests are judged by it from the following cycle.
- R7: A slave with 2^CW-1 outstanding transactions takes no further permitted requests until one completes. Completion is a response handshake with `rsp_last` set.
- R8: Slave responses pass upstream with ID, data, response code and last flag unchanged.
- R9: A request whose `req_slave` index is at or above the slave count is refused as in R3, whatever its protection bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_secure | input | 1 | Protection bit, 1 = secure |
| req_slave | input | SW | Target slave index |
| req_id | input | IDW | Transaction ID |
| req_len | input | LW | Read beats minus one |
| req_wdata | input | DW | Write data |
| m_valid | output | NS | Per-slave forwarded request valid |
| m_ready | input | NS | Per-slave request ready |
| m_write | output | 1 | Forwarded write flag |
| m_secure | output | 1 | Forwarded protection bit |
| m_id | output | IDW | Forwarded ID |
| m_len | output | LW | Forwarded length |
| m_wdata | output | DW | Forwarded write data |
| sl_valid | input | NS | Per-slave response valid |
| sl_ready | output | NS | Per-slave response ready |
| sl_id | input | NS*IDW | Packed slave response IDs |
| sl_data | input | NS*DW | Packed slave response data |
| sl_resp | input | NS*2 | Packed slave response codes |
| sl_last | input | NS | Per-slave last-beat flag |
| rsp_valid | output | 1 | Upstream response valid |
| rsp_ready | input | 1 | Upstream response ready |
| rsp_id | output | IDW | Response ID |
| rsp_data | output | DW | Response data |
| rsp_resp | output | 2 | Response code |
| rsp_last | output | 1 | Last beat |
| cfg_valid | input | 1 | Configuration access |
| cfg_write | input | 1 | 1 = write, 0 = read |
| cfg_secure | input | 1 | Protection bit of the access |
| cfg_sel | input | SW | Slave selected |
| cfg_wdata | input | 1 | New setting, 1 = secure |
| cfg_rsp_valid | output | 1 | Configuration response valid |
| cfg_rsp | output | 2 | 2'b00 done, 2'b11 refused |

## Verification
The bench builds the filter with three slaves, so the two-bit slave index also reaches a value with no slave behind it, which makes the out-of-range refusal reachable. A counter width of two caps each slave at three outstanding transactions, so the saturation stall can be reached within a few requests. Multi-beat error bursts, a change held back behind a live transaction, and refused configuration writes are all driven with these small sizes.

// File: rtl/sec_filter.sv
module sec_filter #(
  parameter int NS  = 4,
  parameter int IDW = 4,
  parameter int LW  = 4,
  parameter int DW  = 32,
  parameter int CW  = 3,
  localparam int SW = (NS > 1) ? $clog2(NS) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic            req_write,
  input  logic            req_secure,
  input  logic [SW-1:0]   req_slave,
  input  logic [IDW-1:0]  req_id,
  input  logic [LW-1:0]   req_len,
  input  logic [DW-1:0]   req_wdata,
  output logic [NS-1:0]   m_valid,
  input  logic [NS-1:0]   m_ready,
  output logic            m_write,
  output logic            m_secure,
  output logic [IDW-1:0]  m_id,
  output logic [LW-1:0]   m_len,
  output logic [DW-1:0]   m_wdata,
  input  logic [NS-1:0]   sl_valid,
  output logic [NS-1:0]   sl_ready,
  input  logic [NS*IDW-1:0] sl_id,
  input  logic [NS*DW-1:0]  sl_data,
  input  logic [NS*2-1:0]   sl_resp,
  input  logic [NS-1:0]   sl_last,
  output logic            rsp_valid,
  input  logic            rsp_ready,
  output logic [IDW-1:0]  rsp_id,
  output logic [DW-1:0]   rsp_data,
  output logic [1:0]      rsp_resp,
  output logic            rsp_last,
  input  logic            cfg_valid,
  input  logic            cfg_write,
  input  logic            cfg_secure,
  input  logic [SW-1:0]   cfg_sel,
  input  logic            cfg_wdata,
  output logic            cfg_rsp_valid,
  output logic [1:0]      cfg_rsp
);

  localparam logic [CW-1:0] CMAX = '1;

  logic [NS-1:0]         act, pend_v, pend_set;
  logic [NS-1:0][CW-1:0] cnt;
  logic [NS-1:0]         hit, cfg_hit, full, inc, dec;
  logic                  allowed, stall, acc_err;

  logic                  err_busy;
  logic [IDW-1:0]        err_id;
  logic [LW-1:0]         err_left;

  logic                  lock_v;
  logic [NS-1:0]         lock_oh, gnt;
  logic                  use_err, slave_hs;

  for (genvar i = 0; i < NS; i++) begin : g_dec
    assign hit[i]     = req_slave == SW'(i);
    assign cfg_hit[i] = cfg_sel == SW'(i);
    assign full[i]    = cnt[i] == CMAX;
  end

  assign allowed = |hit & (req_secure | |(hit & ~act));
  assign stall   = |(hit & pend_v) | (allowed & |(hit & full));
  assign m_valid = {NS{req_valid & allowed & ~stall}} & hit;
  assign req_ready = ~stall & (allowed ? |(hit & m_ready) : ~err_busy);
  assign acc_err = req_valid & req_ready & ~allowed;

  assign m_write  = req_write;
  assign m_secure = req_secure;
  assign m_id     = req_id;
  assign m_len    = req_len;
  assign m_wdata  = req_wdata;

  assign inc = m_valid & m_ready;
  assign dec = sl_valid & sl_ready & sl_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      act      <= '1;
      pend_v   <= '0;
      pend_set <= '1;
    end else begin
      for (int i = 0; i < NS; i++) begin
        if (inc[i] && !dec[i])
          cnt[i] <= cnt[i] + 1'b1;
        else if (dec[i] && !inc[i])
          cnt[i] <= cnt[i] - 1'b1;
        if (cfg_valid && cfg_secure && cfg_write && cfg_hit[i]) begin
          pend_v[i]   <= cfg_wdata != act[i];
          pend_set[i] <= cfg_wdata;
        end else if (pend_v[i] && cnt[i] == '0) begin
          act[i]    <= pend_set[i];
          pend_v[i] <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_rsp_valid <= 1'b0;
      cfg_rsp       <= 2'b00;
    end else begin
      cfg_rsp_valid <= cfg_valid;
      cfg_rsp       <= (cfg_secure && |cfg_hit) ? 2'b00 : 2'b11;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_busy <= 1'b0;
      err_id   <= '0;
      err_left <= '0;
    end else if (acc_err) begin
      err_busy <= 1'b1;
      err_id   <= req_id;
      err_left <= req_write ? '0 : req_len;
    end else if (use_err && rsp_ready) begin
      if (err_left == '0)
        err_busy <= 1'b0;
      else
        err_left <= err_left - 1'b1;
    end
  end

  always_comb begin
    gnt     = '0;
    use_err = 1'b0;
    if (lock_v)
      gnt = lock_oh;
    else if (err_busy)
      use_err = 1'b1;
    else
      for (int i = NS - 1; i >= 0; i--)
        if (sl_valid[i]) gnt = NS'(1) << i;
  end

  always_comb begin
    rsp_id   = '0;
    rsp_data = '0;
    rsp_resp = 2'b00;
    rsp_last = 1'b0;
    for (int i = 0; i < NS; i++)
      if (gnt[i]) begin
        rsp_id   = sl_id[i*IDW +: IDW];
        rsp_data = sl_data[i*DW +: DW];
        rsp_resp = sl_resp[i*2 +: 2];
        rsp_last = sl_last[i];
      end
    if (use_err) begin
      rsp_id   = err_id;
      rsp_resp = 2'b11;
      rsp_last = err_left == '0;
    end
  end

  assign rsp_valid = use_err | |(gnt & sl_valid);
  assign sl_ready  = gnt & {NS{rsp_ready}};
  assign slave_hs  = |(gnt & sl_valid) & rsp_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_v  <= 1'b0;
      lock_oh <= '0;
    end else if (slave_hs) begin
      lock_v  <= ~|(gnt & sl_last);
      lock_oh <= gnt;
    end
  end

endmodule

module sec_filter_chk #(
  parameter int NS = 4,
  parameter int CW = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_secure,
  input logic [NS-1:0]   m_valid,
  input logic [NS-1:0]   m_ready,
  input logic [NS-1:0]   act,
  input logic [NS-1:0]   pend_v,
  input logic [NS-1:0]   pend_set,
  input logic [NS*CW-1:0] cnt_flat,
  input logic            cfg_valid,
  input logic            cfg_secure,
  input logic            cfg_rsp_valid,
  input logic [1:0]      cfg_rsp
);

  p_reset_secure_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> &act);

  p_cfg_refuse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid && !cfg_secure |=> cfg_rsp_valid && cfg_rsp == 2'b11);

  p_cfg_nochange_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid && !cfg_secure |=> $stable(pend_set));

  for (genvar i = 0; i < NS; i++) begin : g_slv
    p_ns_forward_r2: assert property (@(posedge clk) disable iff (!rst_n)
      m_valid[i] && !req_secure |-> !act[i]);

    p_stall_pending_r6: assert property (@(posedge clk) disable iff (!rst_n)
      pend_v[i] |-> !m_valid[i]);

    p_apply_drained_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(act[i]) |-> $past(cnt_flat[i*CW +: CW]) == '0);

    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
      &cnt_flat[i*CW +: CW] |-> !(m_valid[i] && m_ready[i]));
  end

endmodule

bind sec_filter sec_filter_chk #(.NS(NS), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_secure(req_secure),
  .m_valid(m_valid), .m_ready(m_ready), .act(act), .pend_v(pend_v),
  .pend_set(pend_set), .cnt_flat(cnt), .cfg_valid(cfg_valid),
  .cfg_secure(cfg_secure), .cfg_rsp_valid(cfg_rsp_valid), .cfg_rsp(cfg_rsp)
);

// File: tb/sec_filter_test.sv
`timescale 1ns/1ps
module sec_filter_test;
  localparam int NS = 3, IDW = 4, LW = 4, DW = 16, CW = 2, SW = 2;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, req_secure = 0;
  logic [SW-1:0] req_slave = 0;
  logic [IDW-1:0] req_id = 0;
  logic [LW-1:0] req_len = 0;
  logic [DW-1:0] req_wdata = 0;
  logic req_ready;
  logic [NS-1:0] m_valid, m_ready = '1;
  logic m_write, m_secure;
  logic [IDW-1:0] m_id;
  logic [LW-1:0] m_len;
  logic [DW-1:0] m_wdata;
  logic [NS-1:0] sl_valid = 0, sl_last = 0, sl_ready;
  logic [NS*IDW-1:0] sl_id = 0;
  logic [NS*DW-1:0] sl_data = 0;
  logic [NS*2-1:0] sl_resp = 0;
  logic rsp_valid, rsp_ready = 1, rsp_last;
  logic [IDW-1:0] rsp_id;
  logic [DW-1:0] rsp_data;
  logic [1:0] rsp_resp;
  logic cfg_valid = 0, cfg_write = 0, cfg_secure = 0, cfg_wdata = 0;
  logic [SW-1:0] cfg_sel = 0;
  logic cfg_rsp_valid;
  logic [1:0] cfg_rsp;

  int nchk = 0, nerr = 0;

  always #4 clk = ~clk;

  sec_filter #(.NS(NS), .IDW(IDW), .LW(LW), .DW(DW), .CW(CW)) uut (.*);

  // {sec, slave[1:0], write, len[3:0], id[3:0], forwarded}
  localparam logic [12:0] VEC [8] = '{
    {1'b1, 2'd0, 1'b0, 4'd2, 4'd1, 1'b1},
    {1'b0, 2'd0, 1'b0, 4'd2, 4'd2, 1'b0},
    {1'b0, 2'd1, 1'b1, 4'd0, 4'd3, 1'b1},
    {1'b0, 2'd2, 1'b0, 4'd1, 4'd4, 1'b1},
    {1'b1, 2'd2, 1'b1, 4'd0, 4'd5, 1'b1},
    {1'b0, 2'd3, 1'b0, 4'd0, 4'd6, 1'b0},
    {1'b1, 2'd3, 1'b1, 4'd5, 4'd7, 1'b0},
    {1'b0, 2'd0, 1'b1, 4'd7, 4'd8, 1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] a, input logic [31:0] e);
    nchk++;
    if (a !== e) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, a, e);
    end
  endtask

  task automatic cfg_op(input logic sec, input logic wr, input logic [SW-1:0] sel,
                        input logic d, input logic [1:0] exp, input string tag);
    @(negedge clk);
    cfg_valid = 1; cfg_secure = sec; cfg_write = wr; cfg_sel = sel; cfg_wdata = d;
    @(posedge clk); #1 cfg_valid = 0;
    @(negedge clk); #1;
    chk({tag, " cfg_rsp_valid"}, 32'(cfg_rsp_valid), 1);
    chk({tag, " cfg_rsp"}, 32'(cfg_rsp), 32'(exp));
  endtask

  task automatic drive_req(input logic sec, input logic [SW-1:0] slv, input logic wr,
                           input logic [LW-1:0] len, input logic [IDW-1:0] id);
    req_valid = 1; req_secure = sec; req_slave = slv; req_write = wr;
    req_len = len; req_id = id; req_wdata = {12'hD00, id};
  endtask

  task automatic send(input logic sec, input logic [SW-1:0] slv, input logic wr,
                      input logic [LW-1:0] len, input logic [IDW-1:0] id,
                      input logic fwd, input string tag);
    @(negedge clk);
    drive_req(sec, slv, wr, len, id);
    #1;
    chk({tag, " m_valid"}, 32'(m_valid), fwd ? (32'd1 << slv) : 0);
    chk({tag, " req_ready"}, 32'(req_ready), 1);
    if (fwd) begin
      chk({tag, " m_id"}, 32'(m_id), 32'(id));
      chk({tag, " m_len/m_write"}, {m_len, m_write}, {len, wr});
      chk({tag, " m_wdata"}, 32'(m_wdata), {16'h0, 12'hD00, id});
    end
    @(posedge clk); #1 req_valid = 0;
  endtask

  task automatic err_collect(input logic [IDW-1:0] id, input int n, input string tag);
    for (int b = 0; b < n; b++) begin
      @(negedge clk); #1;
      chk({tag, " err rsp_valid"}, 32'(rsp_valid), 1);
      chk({tag, " err rsp_resp"}, 32'(rsp_resp), 3);
      chk({tag, " err rsp_id"}, 32'(rsp_id), 32'(id));
      chk({tag, " err rsp_data"}, 32'(rsp_data), 0);
      chk({tag, " err rsp_last"}, 32'(rsp_last), (b == n - 1) ? 1 : 0);
      @(posedge clk);
    end
  endtask

  task automatic sl_send(input int slv, input logic [IDW-1:0] id, input logic [DW-1:0] d,
                         input logic [1:0] r, input logic last, input string tag);
    @(negedge clk);
    sl_valid[slv] = 1; sl_last[slv] = last;
    sl_id[slv*IDW +: IDW] = id; sl_data[slv*DW +: DW] = d; sl_resp[slv*2 +: 2] = r;
    #1;
    chk({tag, " rsp_valid"}, 32'(rsp_valid), 1);
    chk({tag, " sl_ready"}, 32'(sl_ready[slv]), 1);
    chk({tag, " rsp fields"}, {rsp_id, rsp_data, rsp_resp, rsp_last},
        {id, d, r, last});
    @(posedge clk); #1 sl_valid[slv] = 0;
  endtask

  initial begin
    #(8 * 20000);
    nchk++; nerr++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk); #1;
    chk("R1 reset rsp_valid", 32'(rsp_valid), 0);
    chk("R1 reset m_valid", 32'(m_valid), 0);
    chk("R1 reset cfg_rsp_valid", 32'(cfg_rsp_valid), 0);

    send(0, 1, 0, 4'd1, 4'hA, 0, "R1 ns to slave1");
    err_collect(4'hA, 2, "R1");
    send(0, 2, 1, 4'd0, 4'hB, 0, "R1 ns to slave2");
    err_collect(4'hB, 1, "R1");

    cfg_op(1, 1, 1, 0, 2'b00, "R4 write slave1");
    cfg_op(1, 1, 2, 0, 2'b00, "R4 write slave2");
    cfg_op(1, 0, 0, 0, 2'b00, "R4 read");
    cfg_op(1, 1, 3, 0, 2'b11, "R5 sel out of range");

    for (int k = 0; k < 8; k++) begin
      logic [12:0] v;
      v = VEC[k];
      send(v[12], v[11:10], v[9], v[8:5], v[4:1], v[0], $sformatf("R2 R3 R9 vec%0d", k));
      if (v[0])
        sl_send(int'(v[11:10]), v[4:1], DW'(16'hA000 + k), 2'b00, 1, "R8 vec");
      else
        err_collect(v[4:1], v[9] ? 1 : int'(v[8:5]) + 1, $sformatf("R3 vec%0d", k));
    end

    cfg_op(0, 1, 0, 0, 2'b11, "R5 ns cfg write");
    send(0, 0, 1, 4'd0, 4'h9, 0, "R5 setting unchanged");
    err_collect(4'h9, 1, "R5");
    cfg_op(0, 0, 1, 0, 2'b11, "R5 ns cfg read");

    send(1, 0, 0, 4'd1, 4'h3, 1, "R8 burst");
    sl_send(0, 4'h3, 16'h1234, 2'b10, 0, "R8 beat0");
    sl_send(0, 4'h3, 16'h5678, 2'b01, 1, "R8 beat1");

    send(1, 1, 0, 4'd0, 4'h9, 1, "R6 outstanding");
    cfg_op(1, 1, 1, 1, 2'b00, "R6 make secure");
    @(negedge clk);
    drive_req(0, 1, 1, 4'd0, 4'hC);
    for (int c = 0; c < 3; c++) begin
      #1;
      chk("R6 stall req_ready", 32'(req_ready), 0);
      chk("R6 stall m_valid", 32'(m_valid), 0);
      @(negedge clk);
    end
    sl_valid[1] = 1; sl_last[1] = 1; sl_id[IDW +: IDW] = 4'h9; sl_resp[3:2] = 2'b00;
    #1 chk("R6 drain sl_ready", 32'(sl_ready[1]), 1);
    @(posedge clk); #1 sl_valid[1] = 0;
    @(negedge clk); #1;
    chk("R6 still pending", 32'(req_ready), 0);
    @(negedge clk); #1;
    chk("R6 applied req_ready", 32'(req_ready), 1);
    chk("R6 applied refused", 32'(m_valid), 0);
    @(posedge clk); #1 req_valid = 0;
    err_collect(4'hC, 1, "R6");

    send(1, 0, 1, 4'd0, 4'h1, 1, "R7 fill1");
    send(1, 0, 1, 4'd0, 4'h2, 1, "R7 fill2");
    send(1, 0, 1, 4'd0, 4'h3, 1, "R7 fill3");
    @(negedge clk);
    drive_req(1, 0, 1, 4'd0, 4'h4);
    #1;
    chk("R7 full req_ready", 32'(req_ready), 0);
    chk("R7 full m_valid", 32'(m_valid), 0);
    sl_send(0, 4'h1, 16'h0001, 2'b00, 1, "R7 drain1");
    @(negedge clk); #1;
    chk("R7 freed m_valid", 32'(m_valid), 1);
    chk("R7 freed req_ready", 32'(req_ready), 1);
    @(posedge clk); #1 req_valid = 0;
    sl_send(0, 4'h2, 16'h0002, 2'b00, 1, "R7 drain2");
    sl_send(0, 4'h3, 16'h0003, 2'b00, 1, "R7 drain3");
    sl_send(0, 4'h4, 16'h0004, 2'b00, 1, "R7 drain4");

    @(negedge clk); #1;
    chk("R8 idle rsp_valid", 32'(rsp_valid), 0);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule